// File: doc/BRIEF.md
# ROM-Programmed Four-Phase Load Sequencer

This block is a tiny special-purpose core that runs a fixed program stored on chip, as the loading front end of a block-cipher datapath. One program counter addresses three parallel ROMs. The first gives the opcode, the second the destination number and the third a 32-bit immediate or memory index. Each instruction takes four phases: fetch, decode, execute and writeback. The counter moves on only after writeback.

Two instructions load state. Load-constant writes the immediate to a destination. Load-from-memory reads one word from an external data/key memory and writes it to a destination. That memory has synchronous read and one cycle of latency. Destinations 0 to 7 are the general 32-bit registers; by convention g5 and g6 take the two data halves. Destinations 8 to 11 are four dedicated key registers. An opcode of all ones halts the core, which then raises `done_o` until the next start pulse.

The program in ROM is this listing (opcode, destination, operand), at index 0 upward. 0: (0, 0, 0x12345678). 1: (1, 5, 0). 2: (1, 6, 1). 3: (1, 8, 2). 4: (1, 9, 3). 5: (1, 10, 4). 6: (1, 11, 5). 7: (0, 13, 0xDEADBEEF). 8: (1, 7, 6). 9: (0, 0, 0xFFFFFFFF). 10: (2, 3, 0x55AA55AA). 11: (0, 1, 0x0BADF00D). 12: (15, 0, 0). Every later index holds halt.

Top module: `romseq_core`

## Requirements
- R1: With `rst` high at a clock edge, every general and key register becomes zero, `done_o` and `mem_rd_o` go low, and the core waits idle for a start.
- R2: A `start_i` high at clock edge E0, seen while idle or halted, begins at program index 0. Instruction k takes the four cycles after edges E(4k) to E(4k+3), and its register write lands at edge E(4k+4).
- R3: Opcode 0 (load constant) writes the 32-bit operand to the destination given by the 4-bit destination field.
- R4: Opcode 1 (load from memory) drives `mem_rd_o` high for exactly one cycle, the decode cycle 4k+2, with `mem_addr_o` equal to the low address bits of the operand. The word returned on `mem_data_i` one cycle later is written to the destination.
- R5: Destinations 0..7 select general register gN, exposed at `gpr_o[32*N +: 32]`. Destinations 8..11 select key register K(N-8), exposed at `key_o[32*(N-8) +: 32]`. Destinations 12..15 change no register.
- R6: Any opcode other than 0, 1 and 15 writes no register and issues no memory read, and the sequence continues with the next index.
- R7: Opcode 15 (all ones) halts the core. When the halt sits at index h, `done_o` rises at edge E(4h+2). After that there are no memory reads or register changes, and `done_o` stays high until a start.
- R8: A `start_i` pulse while an instruction sequence is running has no effect on timing or results.
- R9: Start does not clear registers. A restart after halt runs the program again over the existing register contents, and `done_o` drops at the start edge.
- R10: The ROM holds the fixed program listed above. Indices past 12 read as halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle or halted |
| mem_rd_o | output | 1 | Read strobe to the data/key memory |
| mem_addr_o | output | 4 | Word index for the memory read |
| mem_data_i | input | 32 | Memory read data, valid the cycle after the strobe |
| done_o | output | 1 | High while halted |
| gpr_o | output | 256 | General registers g0..g7, g0 in the low word |
| key_o | output | 128 | Key registers K0..K3, K0 in the low word |

## Verification
The bench compares both register banks after each four-cycle slot. A sequencer that moves the counter early, or that samples memory data in the decode cycle instead of one cycle later, then shows shifted or stale words. The ignored destination 13 and the unknown opcode 2 are placed where a broken decoder would overwrite g5 or g3, or start a stray memory read. The done timing is checked in the cycle before and the cycle after its rising edge. A second start pulse is injected mid-program, and the core is restarted over non-zero registers; a design that restarts on the pulse or clears registers on start would give wrong snapshots. The strobe address sequence and count are matched on every run.

// File: rtl/romseq_pkg.sv
package romseq_pkg;

    localparam int OP_W     = 4;
    localparam int DST_W    = 4;
    localparam int IMM_W    = 32;
    localparam int PROG_LEN = 16;
    localparam int PC_W     = $clog2(PROG_LEN);
    localparam int NUM_GPR  = 8;
    localparam int NUM_KEY  = 4;
    localparam int KEY_BASE = NUM_GPR;

    localparam logic [OP_W-1:0] OPC_LDC  = OP_W'(0);
    localparam logic [OP_W-1:0] OPC_LDM  = OP_W'(1);
    localparam logic [OP_W-1:0] OPC_HALT = {OP_W{1'b1}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WB,
        ST_HALT
    } seq_state_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [DST_W-1:0] dst;
        logic [IMM_W-1:0] imm;
    } instr_t;

    typedef struct packed {
        logic             en;
        logic [DST_W-1:0] dst;
        logic [IMM_W-1:0] data;
    } wb_t;

    function automatic instr_t mk(input int op, input int dst, input logic [31:0] imm);
        instr_t r;
        r.op  = OP_W'(op);
        r.dst = DST_W'(dst);
        r.imm = IMM_W'(imm);
        return r;
    endfunction

    // Fixed load program; unlisted indices halt.
    function automatic instr_t prog_instr(input int idx);
        case (idx)
            0:       return mk(0, 0,  32'h1234_5678);
            1:       return mk(1, 5,  32'd0);
            2:       return mk(1, 6,  32'd1);
            3:       return mk(1, 8,  32'd2);
            4:       return mk(1, 9,  32'd3);
            5:       return mk(1, 10, 32'd4);
            6:       return mk(1, 11, 32'd5);
            7:       return mk(0, 13, 32'hDEAD_BEEF);
            8:       return mk(1, 7,  32'd6);
            9:       return mk(0, 0,  32'hFFFF_FFFF);
            10:      return mk(2, 3,  32'h55AA_55AA);
            11:      return mk(0, 1,  32'h0BAD_F00D);
            default: return mk(15, 0, 32'd0);
        endcase
    endfunction

    // Field 0: opcode, 1: destination, 2: operand.
    function automatic logic [31:0] prog_field(input int field, input int idx);
        instr_t w;
        w = prog_instr(idx);
        case (field)
            0:       return 32'(w.op);
            1:       return 32'(w.dst);
            default: return 32'(w.imm);
        endcase
    endfunction

endpackage

// File: rtl/romseq_prog_rom.sv
module romseq_prog_rom #(
    parameter int FIELD = 0,
    parameter int W     = 4,
    parameter int AW    = romseq_pkg::PC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  q
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] table_w [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            assign table_w[i] = W'(romseq_pkg::prog_field(FIELD, i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (rd_en) q <= table_w[addr];
    end
endmodule

// File: rtl/romseq_ctrl.sv
module romseq_ctrl
    import romseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op,
    output seq_state_e        state,
    output logic [PC_W-1:0]   pc,
    output logic              done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc    <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state <= ST_FETCH;
                        pc    <= '0;
                    end
                end
                ST_FETCH:  state <= ST_DECODE;
                ST_DECODE: begin
                    if (op == OPC_HALT) begin
                        state <= ST_HALT;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC:   state <= ST_WB;
                ST_WB: begin
                    pc    <= pc + 1'b1;
                    state <= ST_FETCH;
                end
                ST_HALT: begin
                    if (start_i) begin
                        state <= ST_FETCH;
                        pc    <= '0;
                        done  <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: counter only moves at the end of writeback
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH || state == ST_DECODE || state == ST_EXEC) |=> $stable(pc));

    // R2: phases run in fixed order
    p_phase_order_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC) |=> (state == ST_WB));

    // R7: done holds until a start
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start_i) |=> done);

    // R8: start during a run does not reset the counter
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && state == ST_EXEC) |=> (state == ST_WB));
endmodule

// File: rtl/romseq_regbank.sv
module romseq_regbank
    import romseq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [DST_W-1:0]            dst,
    input  logic [IMM_W-1:0]            data,
    output logic [NUM_GPR*IMM_W-1:0]    gpr_flat,
    output logic [NUM_KEY*IMM_W-1:0]    key_flat
);
    generate
        for (genvar i = 0; i < NUM_GPR; i++) begin : g_gpr
            always_ff @(posedge clk) begin
                if (rst)
                    gpr_flat[i*IMM_W +: IMM_W] <= '0;
                else if (we && dst == DST_W'(i))
                    gpr_flat[i*IMM_W +: IMM_W] <= data;
            end
        end
        for (genvar j = 0; j < NUM_KEY; j++) begin : g_key
            always_ff @(posedge clk) begin
                if (rst)
                    key_flat[j*IMM_W +: IMM_W] <= '0;
                else if (we && dst == DST_W'(KEY_BASE + j))
                    key_flat[j*IMM_W +: IMM_W] <= data;
            end
        end
    endgenerate

    // R5: destinations above the key range leave both banks untouched
    p_ignore_dst_r5: assert property (@(posedge clk) disable iff (rst)
        (we && dst >= DST_W'(KEY_BASE + NUM_KEY)) |=> ($stable(gpr_flat) && $stable(key_flat)));

    // R5: no register changes without a write strobe
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(gpr_flat) && $stable(key_flat)));
endmodule

// File: rtl/romseq_core.sv
module romseq_core
    import romseq_pkg::*;
#(
    parameter int MEM_AW = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    output logic                      mem_rd_o,
    output logic [MEM_AW-1:0]         mem_addr_o,
    input  logic [IMM_W-1:0]          mem_data_i,
    output logic                      done_o,
    output logic [NUM_GPR*IMM_W-1:0]  gpr_o,
    output logic [NUM_KEY*IMM_W-1:0]  key_o
);
    seq_state_e        state;
    logic [PC_W-1:0]   pc;
    instr_t            ir;
    wb_t               wb_q;
    logic              fetch_en;
    logic              we;

    assign fetch_en = (state == ST_FETCH);

    romseq_prog_rom #(.FIELD(0), .W(OP_W)) u_rom_op (
        .clk(clk), .rst(rst), .rd_en(fetch_en), .addr(pc), .q(ir.op));
    romseq_prog_rom #(.FIELD(1), .W(DST_W)) u_rom_a (
        .clk(clk), .rst(rst), .rd_en(fetch_en), .addr(pc), .q(ir.dst));
    romseq_prog_rom #(.FIELD(2), .W(IMM_W)) u_rom_b (
        .clk(clk), .rst(rst), .rd_en(fetch_en), .addr(pc), .q(ir.imm));

    romseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .op(ir.op),
        .state(state), .pc(pc), .done(done_o));

    // Decode issues the memory read; data arrives during execute.
    assign mem_rd_o   = (state == ST_DECODE) && (ir.op == OPC_LDM);
    assign mem_addr_o = ir.imm[MEM_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else if (state == ST_EXEC) begin
            wb_q.en   <= (ir.op == OPC_LDC) || (ir.op == OPC_LDM);
            wb_q.dst  <= ir.dst;
            wb_q.data <= (ir.op == OPC_LDM) ? mem_data_i : ir.imm;
        end
    end

    assign we = (state == ST_WB) && wb_q.en;

    romseq_regbank u_regs (
        .clk(clk), .rst(rst), .we(we), .dst(wb_q.dst), .data(wb_q.data),
        .gpr_flat(gpr_o), .key_flat(key_o));

    // R4: read strobe lasts one cycle and is followed by execute
    p_rd_single_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> (!mem_rd_o && state == ST_EXEC));

    // R3: writeback strobe lasts one cycle
    p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

    // R7: halted core issues no memory read
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_rd_o);

    // R6: unknown opcode never leads to a write
    p_unknown_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir.op != OPC_LDC && ir.op != OPC_LDM) |=> !we);
endmodule

// File: tb/romseq_core_tb_top.sv
`timescale 1ns/1ps
module romseq_core_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic         mem_rd_o;
    logic [3:0]   mem_addr_o;
    logic [31:0]  mem_data_i;
    logic         done_o;
    logic [255:0] gpr_o;
    logic [127:0] key_o;

    int checks   = 0;
    int failures = 0;

    logic [31:0]  mem [16];
    logic [31:0]  eg [8];
    logic [31:0]  ek [4];
    logic [383:0] snap_q [$];
    logic [3:0]   addr_q [$];
    logic [383:0] last_snap;

    int          pop [13];
    int          pa  [13];
    logic [31:0] pb  [13];

    always #2.5 clk = ~clk;

    romseq_core dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mem_rd_o(mem_rd_o),
        .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i), .done_o(done_o),
        .gpr_o(gpr_o), .key_o(key_o));

    // Synchronous-read memory model, one cycle of latency.
    always_ff @(posedge clk) begin
        if (mem_rd_o) mem_data_i <= mem[mem_addr_o];
    end

    task automatic check(input bit ok, input string req, input logic [383:0] act, input logic [383:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [383:0] pack_model();
        logic [383:0] s;
        for (int i = 0; i < 8; i++) s[128 + 32*i +: 32] = eg[i];
        for (int j = 0; j < 4; j++) s[32*j +: 32] = ek[j];
        return s;
    endfunction

    // Driver side: model the listed program and queue expected results.
    task automatic push_program();
        for (int k = 0; k < 12; k++) begin
            logic [31:0] v;
            bit wr;
            wr = 1'b0;
            v  = 32'd0;
            if (pop[k] == 0) begin
                v = pb[k]; wr = 1'b1;
            end else if (pop[k] == 1) begin
                v = mem[pb[k][3:0]]; wr = 1'b1;
                addr_q.push_back(pb[k][3:0]);
            end
            if (wr) begin
                if (pa[k] < 8) eg[pa[k]] = v;
                else if (pa[k] < 12) ek[pa[k]-8] = v;
            end
            snap_q.push_back(pack_model());
        end
    endtask

    // Monitor: start already sampled at edge E0; cycle n sampled at its negedge.
    task automatic run_and_monitor(input bit inject_start);
        int rd_cnt;
        logic [383:0] exp_s;
        logic [3:0] exp_a;
        rd_cnt = 0;
        for (int n = 1; n <= 51; n++) begin
            @(negedge clk);
            if (n == 1) begin
                start_i = 1'b0;
                exp_s = last_snap;
                check({gpr_o, key_o} === exp_s, "R9 registers kept across start", {gpr_o, key_o}, exp_s);
                check(done_o === 1'b0, "R9 done drops at start", 384'(done_o), 384'd0);
            end
            if (inject_start && n == 10) start_i = 1'b1;
            if (inject_start && n == 11) start_i = 1'b0;
            if (mem_rd_o) begin
                rd_cnt++;
                exp_a = (addr_q.size() > 0) ? addr_q.pop_front() : 4'hx;
                check(mem_addr_o === exp_a && (n % 4) == 2, "R4 read address and decode cycle",
                      384'(mem_addr_o), 384'(exp_a));
            end
            if (n % 4 == 1 && n > 1) begin
                exp_s = snap_q.pop_front();
                check({gpr_o, key_o} === exp_s, "R3/R5/R6 register snapshot", {gpr_o, key_o}, exp_s);
                last_snap = exp_s;
            end
            if (n == 50) check(done_o === 1'b0, "R7 done low before halt decode", 384'(done_o), 384'd0);
            if (n == 51) check(done_o === 1'b1, "R7 done high after halt decode", 384'(done_o), 384'd1);
            @(posedge clk);
        end
        check(rd_cnt == 7, "R4 read strobe count", 384'(rd_cnt), 384'd7);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit quiet;
        pop = '{0, 1, 1, 1, 1, 1, 1, 0, 1, 0, 2, 0, 15};
        pa  = '{0, 5, 6, 8, 9, 10, 11, 13, 7, 0, 3, 1, 0};
        pb  = '{32'h1234_5678, 0, 1, 2, 3, 4, 5, 32'hDEAD_BEEF, 6,
                32'hFFFF_FFFF, 32'h55AA_55AA, 32'h0BAD_F00D, 0};
        for (int i = 0; i < 8; i++) eg[i] = 32'd0;
        for (int j = 0; j < 4; j++) ek[j] = 32'd0;
        for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i * 32'h0101_0101;
        last_snap = '0;
        start_i = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check({gpr_o, key_o} === 384'd0 && done_o === 1'b0 && mem_rd_o === 1'b0,
              "R1 reset state", {gpr_o, key_o}, 384'd0);
        repeat (3) @(negedge clk);
        check(mem_rd_o === 1'b0 && done_o === 1'b0, "R1 idle without start",
              384'({mem_rd_o, done_o}), 384'd0);

        // Run 1: R2 timing, R10 listing
        push_program();
        pulse_start();
        run_and_monitor(1'b0);

        // R7: halted core stays quiet
        quiet = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (mem_rd_o !== 1'b0 || done_o !== 1'b1 || {gpr_o, key_o} !== last_snap) quiet = 1'b0;
        end
        check(quiet, "R7 halt holds with no reads or writes", {gpr_o, key_o}, last_snap);

        // Run 2: new memory, restart over live registers, mid-run start (R8, R9)
        for (int i = 0; i < 16; i++) mem[i] = ~(32'h0F0F_0000 ^ (i * 32'h0011_2233));
        push_program();
        pulse_start();
        run_and_monitor(1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule